// File: doc/BRIEF.md
# Passcode-Locked Interrupt Register Front-End

This block is the word-wide register front-end for the interrupt side of a fuse controller. It holds a sticky interrupt status register, a mask register that the bus can only read, two command registers that edit the mask, and one level interrupt output. Neighbouring logic reports events by pulsing per-bit set inputs. The status and mask registers can only be changed by software after the correct passcode has been written to a write-lock register. This guards the interrupt state against stray writes.

After reset the block is locked and every source is masked. Software first writes the 16-bit passcode 0xDF0D to offset 0x00. It then unmasks sources through the enable command register at 0x38 and re-masks them through the disable command register at 0x3C. Pending events are acknowledged by writing ones to the status register at 0x30. Writing any value other than the passcode to offset 0x00 locks the block again.

Top module: `fuse_irq_regs`

## Requirements
- R1: After reset, offset 0x00 reads 1 (locked), the status register at 0x30 reads 0, the mask register at 0x34 reads 0x80007FFF, and `irq` is 0.
- R2: A write of exactly 0x0000DF0D to offset 0x00 makes offset 0x00 read 0 from the next cycle on. A write of any other value there makes it read 1. Writes to offset 0x00 are accepted whether or not the block is locked.
- R3: While offset 0x00 reads 1, a bus write to any other offset changes neither the status register nor the mask register.
- R4: Only status bits 31 and 14..0 exist. Bit 0 is program done, bit 1 is program error, bit 2 is read done, and bit 3 is read error. Reserved status bits read 0, and set pulses on reserved bits have no effect.
- R5: A pulse on `evt_set[i]` for an implemented bit i sets status bit i. The bit stays set until software clears it. Writing 1 to an implemented bit at 0x30 while unlocked clears that bit, and writing 0 leaves it unchanged.
- R6: If a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Bus writes to the mask register at 0x34 have no effect.
- R8: While unlocked, a write to 0x38 clears the mask bits that are written as 1, and a write to 0x3C sets them; only implemented bits change. Offsets 0x38 and 0x3C always read 0.
- R9: `irq` is registered. In each cycle it equals the OR, taken in the previous cycle, of the status bits whose mask bit was 0.
- R10: Reads of any offset other than 0x00, 0x30 and 0x34 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one whole word per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| evt_set | input | DW | Per-bit set pulses from neighbouring logic |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench uses the default parameters: an 8-bit offset, 32-bit data, the 0x80007FFF implemented-bit set and passcode 0xDF0D. With an 8-bit offset, random accesses can reach every mapped register as well as unmapped offsets such as 0x10 and 0xFC. Random writes include the exact passcode often enough that the block moves between the locked and unlocked states many times. The sparse set pulses cover both reserved and implemented bits, so they collide with clears and mask edits in the same cycle.

// File: rtl/fuse_irq_regs.sv
module fuse_irq_regs #(
  parameter int ADDR_W = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] SRC_MASK = 32'h8000_7FFF,
  parameter logic [15:0] PASSCODE = 16'hDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     evt_set,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_LOCK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFF_ENA  = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] OFF_DIS  = ADDR_W'(8'h3C);
  localparam logic [DW-1:0]     KEY_WORD = DW'(PASSCODE);

  logic          lock_q;
  logic [DW-1:0] status_q, mask_q;
  logic          wr_open;
  logic [DW-1:0] clr_bits, ena_bits, dis_bits;

  assign wr_open  = bus_we && !lock_q;
  assign clr_bits = (wr_open && bus_addr == OFF_STAT) ? bus_wdata : '0;
  assign ena_bits = (wr_open && bus_addr == OFF_ENA)  ? (bus_wdata & SRC_MASK) : '0;
  assign dis_bits = (wr_open && bus_addr == OFF_DIS)  ? (bus_wdata & SRC_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b1;
      status_q <= '0;
      mask_q   <= SRC_MASK;
      irq      <= 1'b0;
    end else begin
      if (bus_we && bus_addr == OFF_LOCK)
        lock_q <= (bus_wdata != KEY_WORD);
      status_q <= ((status_q & ~clr_bits) | evt_set) & SRC_MASK;
      mask_q   <= (mask_q & ~ena_bits) | dis_bits;
      irq      <= |(status_q & ~mask_q);
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_LOCK: bus_rdata = {{(DW-1){1'b0}}, lock_q};
      OFF_STAT: bus_rdata = status_q;
      OFF_MASK: bus_rdata = mask_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fuse_irq_regs_chk.sv
module fuse_irq_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] SRC_MASK = 32'h8000_7FFF,
  parameter logic [15:0] PASSCODE = 16'hDF0D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     evt_set,
  input logic              irq,
  input logic              lock_q,
  input logic [DW-1:0]     status_q,
  input logic [DW-1:0]     mask_q
);
  // R2
  lock_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(0) && bus_wdata != DW'(PASSCODE)) |=> lock_q);
  // R2
  lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(0) && bus_wdata == DW'(PASSCODE)) |=> !lock_q);
  // R3
  locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(bus_we && bus_addr == ADDR_W'(0))) |=> $stable(mask_q));
  // R3
  locked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && evt_set == '0) |=> $stable(status_q));
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~SRC_MASK) == '0) && ((mask_q & ~SRC_MASK) == '0));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_set & SRC_MASK)) == $past(evt_set & SRC_MASK)));
  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) != '0) |=> irq);
  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |=> !irq);
endmodule

bind fuse_irq_regs fuse_irq_regs_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .SRC_MASK(SRC_MASK), .PASSCODE(PASSCODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_set(evt_set), .irq(irq),
  .lock_q(lock_q), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/fuse_irq_regs_test.sv
`timescale 1ns/1ps
module fuse_irq_regs_test;
  localparam logic [31:0] IMPL = 32'h8000_7FFF;
  localparam logic [31:0] KEY = 32'h0000_DF0D;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, evt_set = 0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;

  logic m_lock, m_irq;
  logic [31:0] m_stat, m_mask;

  always #2.5 clk = ~clk;

  fuse_irq_regs uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .irq(irq));

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_lock};
      8'h30: return m_stat;
      8'h34: return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 1; m_stat = 0; m_mask = IMPL; m_irq = 0;
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [31:0] ev);
    logic [31:0] clr, en, ds;
    bus_we = we; bus_addr = a; bus_wdata = d; evt_set = ev;
    @(posedge clk);
    clr = (we && !m_lock && a == 8'h30) ? d : 0;
    en  = (we && !m_lock && a == 8'h38) ? d & IMPL : 0;
    ds  = (we && !m_lock && a == 8'h3C) ? d & IMPL : 0;
    m_irq = |(m_stat & ~m_mask);
    if (we && a == 8'h00) m_lock = (d != KEY);
    m_stat = ((m_stat & ~clr) | ev) & IMPL;
    m_mask = (m_mask & ~en) | ds;
    @(negedge clk);
    bus_we = 0; evt_set = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    bus_addr = a; #0.5;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [0:7];
    void'($urandom(32'd1234));
    addrs = '{8'h00, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h10, 8'hFC, 8'h04};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd("R1 lock", 8'h00); rd("R1 status", 8'h30); rd("R1 mask", 8'h34); chk_irq("R1 irq");
    // R3: locked writes ignored
    cyc(1, 8'h38, 32'hFFFF_FFFF, 0); rd("R3 mask locked", 8'h34);
    cyc(0, 8'h00, 0, 32'h1); cyc(1, 8'h30, 32'h1, 0); rd("R3 status locked", 8'h30);
    // R2
    cyc(1, 8'h00, 32'h0001_DF0D, 0); rd("R2 wrong key", 8'h00);
    cyc(1, 8'h00, KEY, 0); rd("R2 unlock", 8'h00);
    // R10, R8 read zero
    rd("R10 unmapped", 8'h10); rd("R8 ena reads0", 8'h38); rd("R8 dis reads0", 8'h3C);
    // R8 enable bit0, R9 timing
    cyc(1, 8'h38, 32'h0000_0001, 0); rd("R8 enable", 8'h34); chk_irq("R9 pending");
    cyc(0, 8'h00, 0, 0); chk_irq("R9 pending next");
    // R5 sticky and clear
    cyc(1, 8'h30, 32'h0, 0); rd("R5 sticky", 8'h30);
    cyc(1, 8'h30, 32'h1, 0); rd("R5 clear", 8'h30); chk_irq("R9 after clear");
    cyc(0, 8'h00, 0, 0); chk_irq("R9 drop");
    // R6 set beats clear
    cyc(1, 8'h30, 32'h1, 32'h1); rd("R6 set wins", 8'h30);
    // R4 reserved bits
    cyc(0, 8'h00, 0, 32'h0010_0000); rd("R4 reserved", 8'h30);
    // R7 mask read only
    cyc(1, 8'h34, 32'h0, 0); rd("R7 mask ro", 8'h34);
    // R8 disable
    cyc(1, 8'h3C, 32'hFFFF_FFFF, 0); rd("R8 disable", 8'h34);
    cyc(0, 8'h00, 0, 0); chk_irq("R9 masked");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [31:0] d, ev;
      a = addrs[$urandom_range(0, 7)];
      d = ($urandom_range(0, 3) == 0) ? KEY : $urandom();
      if (a == 8'h00 && $urandom_range(0, 1) == 0) d = KEY;
      ev = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
      cyc($urandom_range(0, 1) == 1, a, d, ev);
      chk_irq("R9 random");
      rd("R5 random read", addrs[$urandom_range(0, 7)]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule